// File: doc/BRIEF.md
# Crystal Time-Base Divider Chain

This block divides a 32.768 kHz crystal reference down to a family of lower rates. It always counts the crystal clock and never the switchable system clock. A 15-bit binary counter advances once per reference cycle. Each of its bits serves as a square-wave tap at 32768 / 2^(k+1) Hz, from 16384 Hz at bit 0 down to 1 Hz at bit 14. The block forwards the 16 Hz tap to the watchdog counter, and it groups the 32, 64, 128 and 256 Hz taps for the capture unit.

Consumers that want one strobe per period rather than a level get single-reference-cycle tick pulses. These come at 16 Hz and at 1 Hz, on the rising edge of the matching tap. A decade stage counts 16 Hz ticks modulo ten. Its pulse, at 1.6 Hz, coincides with every tenth 16 Hz tick.

A synchronous clear zeroes the binary counter and the decade stage together on the next reference edge. The edge detector for the ticks is built in one of two ways, chosen by a parameter. One decodes the count value and the other compares against a registered copy of the tap. Both give the same output timing.

Top module: `tbdiv_top`

## Requirements
- R1: While `rst_n` is low, `taps_o` is zero and `tick_wd_o`, `tick_sec_o` and `tick_dec_o` are all low.
- R2: With `clr_i` low, `taps_o` increases by exactly one per reference edge and wraps from 32767 to 0.
- R3: `wd_lvl_o` equals `taps_o[10]`, the 16 Hz tap. `cap_taps_o[i]` equals `taps_o[9-i]`, so index 0 is 32 Hz, index 1 is 64 Hz, index 2 is 128 Hz and index 3 is 256 Hz.
- R4: `tick_wd_o` is high for exactly the cycles in which `taps_o` mod 2048 equals 1024, the cycle in which bit 10 has just risen. It is low at all other times.
- R5: `tick_sec_o` is high for exactly the cycles in which `taps_o` equals 16384, the rise of bit 14. It is low at all other times.
- R6: `tick_dec_o` is high only together with `tick_wd_o`. It is high on the 10th, 20th, 30th and so on 16 Hz tick counted since reset or the last clear.
- R7: A reference edge that samples `clr_i` high sets `taps_o` to zero and restarts the decade count at zero.
- R8: Clear takes precedence over counting. While `clr_i` is held high, `taps_o` stays zero and no tick is produced.
- R9: After `clr_i` is released, the first 16 Hz tick comes 1024 reference edges later. The first 1.6 Hz pulse comes 19456 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | 32.768 kHz crystal reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of the counter and the decade stage |
| taps_o | output | 15 | Binary counter; bit k is the 32768/2^(k+1) Hz tap |
| wd_lvl_o | output | 1 | 16 Hz level for the watchdog counter |
| cap_taps_o | output | 4 | Capture taps: 32, 64, 128 and 256 Hz at index 0 to 3 |
| tick_wd_o | output | 1 | One-cycle pulse on each rise of the 16 Hz tap |
| tick_sec_o | output | 1 | One-cycle pulse on each rise of the 1 Hz tap |
| tick_dec_o | output | 1 | One-cycle 1.6 Hz pulse on every tenth 16 Hz tick |

## Verification
The hardest situation to reach is a clear that lands while the decade stage holds a partial count, after the binary counter has already wrapped. The decade pulse must then come a full 19456 edges after release, not at the leftover count. The stimulus runs past one counter wrap and past several decade pulses, and then applies a clear at an arbitrary count. It holds that clear for several cycles and then runs long enough to see the first 16 Hz tick and the first 1.6 Hz pulse after release. A behavioural model built on integer arithmetic is compared against every output on every cycle.

// File: rtl/tbdiv_pkg.sv
package tbdiv_pkg;
   localparam int REF_HZ = 32768;

   typedef struct packed {
      logic wd;
      logic sec;
      logic dec;
   } tick_t;

   function automatic int tap_hz(input int tap);
      return REF_HZ >> (tap + 1);
   endfunction
endpackage

// File: rtl/tbdiv_chain.sv
module tbdiv_chain #(
   parameter int CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   output logic [CNT_W-1:0] cnt_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clr_i) cnt_q <= '0;
      else            cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;

   // R2
   inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

   // R7
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> cnt_q == '0);
endmodule

// File: rtl/tbdiv_rise.sv
module tbdiv_rise #(
   parameter int TAP    = 10,
   parameter bit DECODE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [TAP:0] low_i,
   output logic         tick_o
);
   if (TAP < 1) begin : g_bad_tap
      $error("tbdiv_rise: TAP must be at least 1");
   end

   if (DECODE) begin : g_decode
      localparam logic [TAP:0] HIT = {1'b1, {TAP{1'b0}}};
      assign tick_o = (low_i == HIT);
   end else begin : g_prev
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= low_i[TAP];
      end
      assign tick_o = low_i[TAP] & ~prev_q;
   end

   // R4
   tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);
endmodule

// File: rtl/tbdiv_decade.sv
module tbdiv_decade #(
   parameter int RATIO = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic step_i,
   output logic wrap_o
);
   localparam int DW = (RATIO > 2) ? $clog2(RATIO) : 1;
   localparam logic [DW-1:0] LAST = DW'(RATIO - 1);

   logic [DW-1:0] dcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dcnt_q <= '0;
      else if (clr_i)   dcnt_q <= '0;
      else if (step_i)  dcnt_q <= (dcnt_q == LAST) ? '0 : dcnt_q + 1'b1;
   end

   assign wrap_o = step_i && (dcnt_q == LAST);

   // R6
   dec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dcnt_q <= LAST);

   // R6
   dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && !clr_i) |=> $stable(dcnt_q));

   // R7
   dec_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> dcnt_q == '0);
endmodule

// File: rtl/tbdiv_top.sv
module tbdiv_top #(
   parameter int CNT_W       = 15,
   parameter int WD_TAP      = 10,
   parameter int SEC_TAP     = 14,
   parameter int CAP_LO_TAP  = 6,
   parameter int CAP_N       = 4,
   parameter int DEC_RATIO   = 10,
   parameter bit TICK_DECODE = 1'b1
) (
   input  logic             clk_ref,
   input  logic             rst_n,
   input  logic             clr_i,
   output logic [CNT_W-1:0] taps_o,
   output logic             wd_lvl_o,
   output logic [CAP_N-1:0] cap_taps_o,
   output logic             tick_wd_o,
   output logic             tick_sec_o,
   output logic             tick_dec_o
);
   import tbdiv_pkg::*;

   localparam int CAP_HI_TAP = CAP_LO_TAP + CAP_N - 1;

   if (WD_TAP < 1 || WD_TAP >= CNT_W || SEC_TAP < 1 || SEC_TAP >= CNT_W) begin : g_bad_tick
      $error("tbdiv_top: tick taps outside the counter");
   end
   if (CAP_HI_TAP >= CNT_W || CAP_LO_TAP < 0) begin : g_bad_cap
      $error("tbdiv_top: capture taps outside the counter");
   end
   if (DEC_RATIO < 2) begin : g_bad_ratio
      $error("tbdiv_top: decade ratio must be at least 2");
   end

   logic [CNT_W-1:0] cnt;
   tick_t            ticks;

   tbdiv_chain #(.CNT_W(CNT_W)) u_chain (
      .clk   (clk_ref),
      .rst_n (rst_n),
      .clr_i (clr_i),
      .cnt_o (cnt)
   );

   tbdiv_rise #(.TAP(WD_TAP), .DECODE(TICK_DECODE)) u_rise_wd (
      .clk    (clk_ref),
      .rst_n  (rst_n),
      .low_i  (cnt[WD_TAP:0]),
      .tick_o (ticks.wd)
   );

   tbdiv_rise #(.TAP(SEC_TAP), .DECODE(TICK_DECODE)) u_rise_sec (
      .clk    (clk_ref),
      .rst_n  (rst_n),
      .low_i  (cnt[SEC_TAP:0]),
      .tick_o (ticks.sec)
   );

   tbdiv_decade #(.RATIO(DEC_RATIO)) u_decade (
      .clk    (clk_ref),
      .rst_n  (rst_n),
      .clr_i  (clr_i),
      .step_i (ticks.wd),
      .wrap_o (ticks.dec)
   );

   for (genvar i = 0; i < CAP_N; i++) begin : g_cap
      assign cap_taps_o[i] = cnt[CAP_HI_TAP - i];
   end

   assign taps_o     = cnt;
   assign wd_lvl_o   = cnt[WD_TAP];
   assign tick_wd_o  = ticks.wd;
   assign tick_sec_o = ticks.sec;
   assign tick_dec_o = ticks.dec;

   // R6
   dec_with_wd_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      tick_dec_o |-> tick_wd_o);

   // R8
   clr_quiet_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      clr_i |=> (!tick_wd_o && !tick_sec_o && !tick_dec_o));

   // R3
   wd_level_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $rose(tick_wd_o) |-> wd_lvl_o);
endmodule

// File: tb/tbdiv_top_bench.sv
module tbdiv_top_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic [14:0] taps;
   logic        wd_lvl;
   logic [3:0]  cap;
   logic        t_wd, t_sec, t_dec;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   int m_cnt = 0;
   int m_dec = 0;

   always #5 clk = ~clk;

   tbdiv_top u_tbdiv_top (
      .clk_ref    (clk),
      .rst_n      (rst_n),
      .clr_i      (clr),
      .taps_o     (taps),
      .wd_lvl_o   (wd_lvl),
      .cap_taps_o (cap),
      .tick_wd_o  (t_wd),
      .tick_sec_o (t_sec),
      .tick_dec_o (t_dec)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s at count %0d: actual %0d expected %0d", req, m_cnt, act, exp);
      end
   endtask

   function automatic bit m_wd_tick();
      return (m_cnt % 2048) == 1024;
   endfunction

   task automatic compare_all();
      int ecap;
      ecap = 0;
      for (int i = 0; i < 4; i++) ecap |= ((m_cnt >> (9 - i)) & 1) << i;
      chk(int'(taps) == m_cnt, "R2 taps", int'(taps), m_cnt);
      chk(int'(wd_lvl) == ((m_cnt >> 10) & 1), "R3 wd level", int'(wd_lvl), (m_cnt >> 10) & 1);
      chk(int'(cap) == ecap, "R3 capture taps", int'(cap), ecap);
      chk(t_wd == m_wd_tick(), "R4 16Hz tick", int'(t_wd), int'(m_wd_tick()));
      chk(t_sec == (m_cnt == 16384), "R5 1Hz tick", int'(t_sec), int'(m_cnt == 16384));
      chk(t_dec == (m_wd_tick() && m_dec == 9), "R6 decade pulse", int'(t_dec),
          int'(m_wd_tick() && m_dec == 9));
   endtask

   task automatic step(input bit c);
      bit tk;
      clr = c;
      tk  = m_wd_tick();
      @(posedge clk);
      if (c) begin
         m_cnt = 0;
         m_dec = 0;
      end else begin
         if (tk) m_dec = (m_dec + 1) % 10;
         m_cnt = (m_cnt + 1) % 32768;
      end
      @(negedge clk);
      compare_all();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end

   initial begin
      int n_dec;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(taps == '0, "R1 taps in reset", int'(taps), 0);
      chk({t_wd, t_sec, t_dec} == 3'b000, "R1 ticks in reset", int'({t_wd, t_sec, t_dec}), 0);
      rst_n = 1'b1;
      compare_all();

      // free run across a counter wrap (R2) and several decade pulses (R6)
      n_dec = 0;
      for (int i = 0; i < 70000; i++) begin
         step(1'b0);
         if (t_dec) n_dec++;
      end
      // pulses at 19456 + 20480*k below 70000: k = 0, 1, 2
      chk(n_dec == 3, "R6 decade pulse count", n_dec, 3);

      // R7: clear at a partial count
      step(1'b1);
      chk(taps == '0, "R7 taps after clear", int'(taps), 0);
      // R8: clear held
      for (int i = 0; i < 5; i++) begin
         step(1'b1);
         chk(taps == '0 && !t_wd && !t_sec && !t_dec, "R8 clear held", int'(taps), 0);
      end

      // R9: release; first 16 Hz tick 1024 edges later
      for (int i = 0; i < 1023; i++) step(1'b0);
      chk(!t_wd, "R9 no early tick", int'(t_wd), 0);
      step(1'b0);
      chk(t_wd, "R9 first tick after release", int'(t_wd), 1);

      // R9: first decade pulse at 19456 after release
      for (int i = 1024; i < 19455; i++) step(1'b0);
      chk(!t_dec, "R9 no early decade pulse", int'(t_dec), 0);
      step(1'b0);
      chk(t_dec, "R9 first decade pulse after release", int'(t_dec), 1);

      for (int i = 0; i < 3000; i++) step(1'b0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end
endmodule